// File: doc/BRIEF.md
# Interrupt-Started Single-Transfer DMA Engine

This block moves one data item from a source address to a destination address each time a start source asks for service. There are 34 start sources: 33 interrupt request lines and one software start. Each source has its own slot of settings: a source pointer, a destination pointer, a mode and a 16-bit remaining-transfer count. Software loads these settings through a simple register write port. A request is latched only while that source is enabled.

When one or more requests are pending, the engine takes the lowest-numbered one and raises a bus request. After the grant it holds the bus for a fixed service slot of four states. The first two are instruction-fetch states left to the processor. The third is a read state and the fourth is a write state. The engine then steps both pointers, counts down, and drops the bus request.

When the count of a source runs out, the engine raises a one-cycle completion flag for that source and disables it. The pointers are 32 bits wide, but only their low 24 bits reach the address bus.

Top module: `udma_engine`

## Requirements
- R1: After reset every source is disabled, no request is pending, and `bus_req`, `mem_rd`, `mem_wr`, `fetch_slot` and `done_vec` are all low.
- R2: A pulse on a source's request line (bit i of `irq_req` for i below 33, or `sw_start` for source 33) is latched only if that source is enabled. A request on a disabled source causes no bus activity.
- R3: Among pending sources the lowest index is served first. A source makes exactly one transfer per service, and repeated pulses that arrive while it is still waiting merge into that single transfer.
- R4: A service slot raises `bus_req` and waits for `bus_gnt`. It then runs two states with `fetch_slot` high, then one state with `mem_rd` high, then one state with `mem_wr` high. `bus_req` is low in the cycle after the write state.
- R5: `mem_addr` carries the low 24 bits of the source pointer in the read state and of the destination pointer in the write state. Bits 31..24 of a pointer never affect the bus.
- R6: Mode bits [1:0] give the size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. A byte uses `mem_be` = 0001 shifted left by address bits [1:0]. A 2-byte item uses 0011, or 1100 when address bit 1 is set. A 4-byte item uses 1111. The item is taken from the read lanes and written at the destination lanes, and disabled write lanes are zero.
- R7: Mode bits [3:2] act on the source pointer and bits [5:4] act on the destination pointer: 0 = hold, 1 = add the size in bytes, 2 = subtract it. The arithmetic covers all 32 bits.
- R8: The count drops by one after each service. When a service starts with count 1, bit i of `done_vec` is high for the one cycle after the write state and source i becomes disabled.
- R9: A count of 0 means 65536 transfers: a service that starts at 0 raises no completion flag and leaves the source enabled.
- R10: A reserved mode (size 3, or a pointer action of 3) still runs the slot and decrements the count, but it raises no read or write strobe and leaves both pointers unchanged.
- R11: The software start is source 33 and has the lowest priority of all sources.
- R12: A configuration write selects a source with `cfg_idx` and a register with `cfg_field`: 0 = source pointer, 1 = destination pointer, 2 = mode in wdata[5:0] plus the enable bit in wdata[7], 3 = count in wdata[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 33 | Interrupt start pulses, one per source |
| sw_start | input | 1 | Software start pulse (source 33) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Source selected for the write |
| cfg_field | input | 2 | Register selected for the write |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | output | 1 | Engine wants or holds the bus |
| bus_gnt | input | 1 | Bus granted to the engine |
| fetch_slot | output | 1 | Processor fetch state inside the slot |
| mem_addr | output | 24 | Bus address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, sampled at the end of the read state |
| done_vec | output | 34 | Per-source completion pulse |

## Verification
The assertions assume several things about the inputs. The grant stays high once given until `bus_req` falls. Read data is valid in the read state. 2-byte and 4-byte pointers are aligned, and configuration writes do not target a source while it is being served. The stimulus keeps to these rules. A grant model answers each request after a random delay of zero to three cycles and holds the grant. Random pointers are masked to the chosen size. Each source is reconfigured only after its slots have drained, and read data is a fixed hash of the address.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int REG_AW = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_F1,
        ST_F2,
        ST_RD,
        ST_WR
    } state_e;

    typedef struct packed {
        logic [1:0] dst_act;
        logic [1:0] src_act;
        logic [1:0] size;
    } mode_t;

    localparam logic [1:0] ACT_HOLD = 2'd0;
    localparam logic [1:0] ACT_INC  = 2'd1;
    localparam logic [1:0] ACT_DEC  = 2'd2;
    localparam logic [1:0] ACT_RSV  = 2'd3;
    localparam logic [1:0] SZ_RSV   = 2'd3;

    function automatic logic mode_reserved(mode_t m);
        return (m.size == SZ_RSV) || (m.src_act == ACT_RSV) || (m.dst_act == ACT_RSV);
    endfunction

    function automatic logic [REG_AW-1:0] step_of(logic [1:0] sz);
        return REG_AW'(1) << sz;
    endfunction

    function automatic logic [REG_AW-1:0] advance(logic [REG_AW-1:0] a,
                                                  logic [1:0] act,
                                                  logic [REG_AW-1:0] st);
        case (act)
            ACT_INC: return a + st;
            ACT_DEC: return a - st;
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/udma_prio.sv
module udma_prio #(
    parameter int N     = 34,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    always_comb begin
        valid  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid  = 1'b1;
                idx    = IDX_W'(i);
                onehot = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/udma_lane.sv
module udma_lane
    import udma_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        rd_lo,
    input  logic [1:0]        wr_lo,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] held,
    output logic [LANES-1:0]  rd_be,
    output logic [LANES-1:0]  wr_be,
    output logic [DATA_W-1:0] rd_low,
    output logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mask;

    function automatic logic [LANES-1:0] lanes_of(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            2'd0:    return LANES'(1) << lo;
            2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    always_comb begin
        case (size)
            2'd0:    mask = DATA_W'(32'h0000_00FF);
            2'd1:    mask = DATA_W'(32'h0000_FFFF);
            default: mask = '1;
        endcase
        rd_be   = lanes_of(size, rd_lo);
        wr_be   = lanes_of(size, wr_lo);
        rd_low  = (rdata >> {rd_lo, 3'b000}) & mask;
        wr_data = (held & mask) << {wr_lo, 3'b000};
    end
endmodule

// File: rtl/udma_regfile.sv
module udma_regfile
    import udma_pkg::*;
#(
    parameter int NUM_SRC = 34,
    parameter int CNT_W   = 16,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [1:0]          cfg_field,
    input  logic [REG_AW-1:0]   cfg_wdata,
    input  logic                upd_en,
    input  logic [IDX_W-1:0]    upd_idx,
    input  logic [REG_AW-1:0]   upd_src,
    input  logic [REG_AW-1:0]   upd_dst,
    input  logic [CNT_W-1:0]    upd_cnt,
    input  logic                upd_clr_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [REG_AW-1:0]   rd_src,
    output logic [REG_AW-1:0]   rd_dst,
    output mode_t               rd_mode,
    output logic [CNT_W-1:0]    rd_cnt,
    output logic [NUM_SRC-1:0]  en_vec
);
    typedef struct packed {
        logic [REG_AW-1:0] src;
        logic [REG_AW-1:0] dst;
        mode_t             mode;
        logic [CNT_W-1:0]  cnt;
        logic              en;
    } slot_t;

    slot_t [NUM_SRC-1:0] all_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        slot_t ent_d, ent_q;
        logic  hit_upd, hit_cfg;

        assign hit_upd = upd_en && (upd_idx == IDX_W'(i));
        assign hit_cfg = cfg_we && (cfg_idx == IDX_W'(i));

        always_comb begin
            ent_d = ent_q;
            if (hit_upd) begin
                ent_d.src = upd_src;
                ent_d.dst = upd_dst;
                ent_d.cnt = upd_cnt;
                if (upd_clr_en) ent_d.en = 1'b0;
            end
            if (hit_cfg) begin
                case (cfg_field)
                    2'd0: ent_d.src = cfg_wdata;
                    2'd1: ent_d.dst = cfg_wdata;
                    2'd2: begin
                        ent_d.mode = mode_t'(cfg_wdata[5:0]);
                        ent_d.en   = cfg_wdata[7];
                    end
                    default: ent_d.cnt = cfg_wdata[CNT_W-1:0];
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign all_q[i]  = ent_q;
        assign en_vec[i] = ent_q.en;

        assert_expiry_disables_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_upd && upd_clr_en && !hit_cfg) |=> !ent_q.en);
    end

    assign rd_src  = all_q[rd_idx].src;
    assign rd_dst  = all_q[rd_idx].dst;
    assign rd_mode = all_q[rd_idx].mode;
    assign rd_cnt  = all_q[rd_idx].cnt;
endmodule

// File: rtl/udma_engine.sv
module udma_engine
    import udma_pkg::*;
#(
    parameter int NUM_IRQ = 33,
    parameter int CNT_W   = 16,
    parameter int BUS_AW  = 24,
    localparam int NUM_SRC = NUM_IRQ + 1,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_req,
    input  logic                sw_start,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [1:0]          cfg_field,
    input  logic [REG_AW-1:0]   cfg_wdata,
    output logic                bus_req,
    input  logic                bus_gnt,
    output logic                fetch_slot,
    output logic [BUS_AW-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [LANES-1:0]    mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [NUM_SRC-1:0]  done_vec
);
    typedef struct packed {
        state_e             state;
        logic [IDX_W-1:0]   cur;
        logic [DATA_W-1:0]  data;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] done;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [NUM_SRC-1:0] req_all, en_vec, arb_in, arb_onehot;
    logic               arb_valid;
    logic [IDX_W-1:0]   arb_idx;
    logic [REG_AW-1:0]  cur_src, cur_dst, st;
    mode_t              cur_mode;
    logic [CNT_W-1:0]   cur_cnt;
    logic               rsv;
    logic [LANES-1:0]   rd_be, wr_be;
    logic [DATA_W-1:0]  rd_low, wr_data;
    logic               upd_en, upd_clr_en;
    logic [REG_AW-1:0]  upd_src, upd_dst;
    logic [CNT_W-1:0]   upd_cnt;

    assign req_all = {sw_start, irq_req};
    assign arb_in  = eng_q.pend & en_vec;

    udma_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .req    (arb_in),
        .valid  (arb_valid),
        .idx    (arb_idx),
        .onehot (arb_onehot)
    );

    udma_regfile #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_field  (cfg_field),
        .cfg_wdata  (cfg_wdata),
        .upd_en     (upd_en),
        .upd_idx    (eng_q.cur),
        .upd_src    (upd_src),
        .upd_dst    (upd_dst),
        .upd_cnt    (upd_cnt),
        .upd_clr_en (upd_clr_en),
        .rd_idx     (eng_q.cur),
        .rd_src     (cur_src),
        .rd_dst     (cur_dst),
        .rd_mode    (cur_mode),
        .rd_cnt     (cur_cnt),
        .en_vec     (en_vec)
    );

    udma_lane u_lane (
        .size    (cur_mode.size),
        .rd_lo   (cur_src[1:0]),
        .wr_lo   (cur_dst[1:0]),
        .rdata   (mem_rdata),
        .held    (eng_q.data),
        .rd_be   (rd_be),
        .wr_be   (wr_be),
        .rd_low  (rd_low),
        .wr_data (wr_data)
    );

    assign rsv = mode_reserved(cur_mode);
    assign st  = step_of(cur_mode.size);

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = '0;
        eng_d.pend = (eng_q.pend | req_all) & en_vec;
        upd_en     = 1'b0;
        upd_clr_en = 1'b0;
        upd_src    = rsv ? cur_src : advance(cur_src, cur_mode.src_act, st);
        upd_dst    = rsv ? cur_dst : advance(cur_dst, cur_mode.dst_act, st);
        upd_cnt    = cur_cnt - CNT_W'(1);
        case (eng_q.state)
            ST_IDLE: if (arb_valid) begin
                eng_d.cur   = arb_idx;
                eng_d.pend  = ((eng_q.pend & ~arb_onehot) | req_all) & en_vec;
                eng_d.state = ST_REQ;
            end
            ST_REQ: if (bus_gnt) eng_d.state = ST_F1;
            ST_F1:  eng_d.state = ST_F2;
            ST_F2:  eng_d.state = ST_RD;
            ST_RD: begin
                if (!rsv) eng_d.data = rd_low;
                eng_d.state = ST_WR;
            end
            ST_WR: begin
                upd_en = 1'b1;
                if (cur_cnt == CNT_W'(1)) begin
                    upd_clr_en = 1'b1;
                    eng_d.done = NUM_SRC'(1) << eng_q.cur;
                end
                eng_d.state = ST_IDLE;
            end
            default: eng_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{state: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    always_comb begin
        bus_req    = eng_q.state != ST_IDLE;
        fetch_slot = (eng_q.state == ST_F1) || (eng_q.state == ST_F2);
        mem_rd     = (eng_q.state == ST_RD) && !rsv;
        mem_wr     = (eng_q.state == ST_WR) && !rsv;
        mem_addr   = '0;
        mem_be     = '0;
        mem_wdata  = '0;
        if (mem_rd) begin
            mem_addr = cur_src[BUS_AW-1:0];
            mem_be   = rd_be;
        end
        if (mem_wr) begin
            mem_addr  = cur_dst[BUS_AW-1:0];
            mem_be    = wr_be;
            mem_wdata = wr_data;
        end
    end

    assign done_vec = eng_q.done;

    assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_write_follows_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_WR) |-> ($past(eng_q.state) == ST_RD));
    assert_read_follows_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_RD) |-> ($past(eng_q.state) == ST_F2));
    assert_strobe_holds_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || fetch_slot) |-> bus_req);
    assert_lowest_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> (((arb_onehot - NUM_SRC'(1)) & arb_in) == '0) && ((arb_onehot & arb_in) != '0));
    assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));
    assert_done_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_vec & en_vec) == '0) || $past(cfg_we));
endmodule

// File: tb/udma_engine_test.sv
module udma_engine_test;
    localparam int NS = 34;

    logic        clk = 0, rst_n = 0;
    logic [32:0] irq_req = '0;
    logic        sw_start = 0, cfg_we = 0, bus_gnt = 0;
    logic [5:0]  cfg_idx = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        bus_req, fetch_slot, mem_rd, mem_wr;
    logic [23:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic [NS-1:0] done_vec;

    int checks = 0, fails = 0, cycles = 0;
    logic [31:0] m_src [NS];
    logic [31:0] m_dst [NS];
    logic [5:0]  m_mode [NS];
    logic [15:0] m_cnt [NS];
    logic        m_en [NS];

    udma_engine uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_start(sw_start),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .fetch_slot(fetch_slot),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done_vec(done_vec)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] hash_word(logic [23:0] a);
        return ({8'h00, a[23:2], 2'b00} ^ 32'h5A3C_96E1) * 32'h0001_0193 + 32'h1357_9BDF;
    endfunction
    assign mem_rdata = hash_word(mem_addr);

    function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] lo);
        if (sz == 0) return 4'b0001 << lo;
        if (sz == 1) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction
    function automatic logic [31:0] exp_item(logic [1:0] sz, logic [31:0] w, logic [1:0] lo);
        logic [31:0] v = w >> (8 * lo);
        if (sz == 0) return v & 32'hFF;
        if (sz == 1) return v & 32'hFFFF;
        return v;
    endfunction
    function automatic logic is_rsv(logic [5:0] m);
        return m[1:0] == 3 || m[3:2] == 3 || m[5:4] == 3;
    endfunction
    function automatic logic [31:0] step_addr(logic [31:0] a, logic [1:0] act, logic [1:0] sz);
        logic [31:0] s = 32'd1 << sz;
        if (act == 1) return a + s;
        if (act == 2) return a - s;
        return a;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(int idx, int field, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 6'(idx); cfg_field = 2'(field); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic setup(int idx, logic [31:0] s, logic [31:0] d, logic [5:0] md,
                         logic [15:0] c, logic en);
        cfg_write(idx, 0, s);
        cfg_write(idx, 1, d);
        cfg_write(idx, 3, {16'h0, c});
        cfg_write(idx, 2, {24'h0, en, 1'b0, md});
        m_src[idx] = s; m_dst[idx] = d; m_mode[idx] = md; m_cnt[idx] = c; m_en[idx] = en;
    endtask

    task automatic pulse(logic [NS-1:0] v);
        @(negedge clk);
        irq_req = v[32:0]; sw_start = v[33];
        @(negedge clk);
        irq_req = '0; sw_start = 0;
    endtask

    task automatic expect_quiet(string req, int n);
        logic seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (bus_req) seen = 1;
        end
        check(req, 64'(seen), 64'd0);
    endtask

    task automatic expect_slot(int idx);
        int w = 0;
        logic [31:0] item;
        logic rs = is_rsv(m_mode[idx]);
        logic [1:0] sz = m_mode[idx][1:0];
        logic [NS-1:0] dn;
        while (!fetch_slot && w < 60) begin
            @(negedge clk);
            w++;
        end
        check("R4 slot start", 64'(fetch_slot), 64'd1);
        check("R4 bus held", 64'(bus_req), 64'd1);
        @(negedge clk);
        check("R4 second fetch", {62'd0, fetch_slot, mem_rd}, 64'b10);
        @(negedge clk);
        if (rs) begin
            check("R10 no read", {62'd0, mem_rd, mem_wr}, 64'd0);
        end else begin
            check("R4 read", 64'(mem_rd), 64'd1);
            check("R5 R7 read addr", 64'(mem_addr), 64'(m_src[idx][23:0]));
            check("R6 read be", 64'(mem_be), 64'(exp_be(sz, m_src[idx][1:0])));
        end
        item = exp_item(sz, hash_word(m_src[idx][23:0]), m_src[idx][1:0]);
        @(negedge clk);
        if (rs) begin
            check("R10 no write", {62'd0, mem_rd, mem_wr}, 64'd0);
        end else begin
            check("R4 write", {62'd0, mem_wr, mem_rd}, 64'b10);
            check("R5 R7 write addr", 64'(mem_addr), 64'(m_dst[idx][23:0]));
            check("R6 write be", 64'(mem_be), 64'(exp_be(sz, m_dst[idx][1:0])));
            check("R6 write data", 64'(mem_wdata), 64'(item << (8 * m_dst[idx][1:0])));
        end
        dn = (m_cnt[idx] == 16'd1) ? (NS'(1) << idx) : '0;
        @(negedge clk);
        check("R8 R9 done", 64'(done_vec), 64'(dn));
        check("R4 bus released", 64'(bus_req), 64'd0);
        if (!rs) begin
            m_src[idx] = step_addr(m_src[idx], m_mode[idx][3:2], sz);
            m_dst[idx] = step_addr(m_dst[idx], m_mode[idx][5:4], sz);
        end
        if (m_cnt[idx] == 16'd1) m_en[idx] = 0;
        m_cnt[idx] = m_cnt[idx] - 16'd1;
    endtask

    initial begin : grant_model
        int gd = 0;
        forever begin
            @(negedge clk);
            if (!bus_req) begin
                bus_gnt = 0;
                gd = $urandom % 4;
            end else if (gd == 0) bus_gnt = 1;
            else gd--;
        end
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        int unsigned seed = $urandom(32'd4242);
        seed = seed;
        for (int i = 0; i < NS; i++) begin
            m_src[i] = 0; m_dst[i] = 0; m_mode[i] = 0; m_cnt[i] = 0; m_en[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 outputs idle", {59'd0, bus_req, mem_rd, mem_wr, fetch_slot, |done_vec}, 64'd0);
        rst_n = 1;
        // R1 R2 all sources disabled out of reset
        pulse({NS{1'b1}});
        expect_quiet("R1 R2 disabled after reset", 10);

        // R5 upper pointer bits ignored; R12 field writes
        setup(3, 32'hAB00_0010, 32'hCD00_0203, 6'b01_01_00, 16'd2, 1);
        pulse(NS'(1) << 3); expect_slot(3);
        pulse(NS'(1) << 3); expect_slot(3);
        // R8 source disabled after expiry
        pulse(NS'(1) << 3);
        expect_quiet("R8 disabled after expiry", 10);

        // R7 decrement across zero, 4-byte, destination held
        setup(5, 32'h0000_0000, 32'h0000_1000, 6'b00_10_10, 16'd2, 1);
        pulse(NS'(1) << 5); expect_slot(5);
        pulse(NS'(1) << 5); expect_slot(5);

        // R3 R11 priority: sources 2, 7 and software start together
        setup(2, 32'h100, 32'h200, 6'b01_01_01, 16'd5, 1);
        setup(7, 32'h302, 32'h402, 6'b10_01_01, 16'd5, 1);
        setup(33, 32'h501, 32'h603, 6'b01_10_00, 16'd5, 1);
        pulse((NS'(1) << 33) | (NS'(1) << 7) | (NS'(1) << 2));
        expect_slot(2); expect_slot(7); expect_slot(33);
        expect_quiet("R3 one transfer each", 10);

        // R3 merged pulses while waiting
        setup(4, 32'h700, 32'h800, 6'b01_01_10, 16'd9, 1);
        setup(9, 32'h900, 32'hA00, 6'b01_01_00, 16'd9, 1);
        pulse((NS'(1) << 4) | (NS'(1) << 9));
        pulse(NS'(1) << 9);
        expect_slot(4); expect_slot(9);
        expect_quiet("R3 merged request", 10);

        // R9 count zero keeps going without completion
        setup(12, 32'h40, 32'h80, 6'b01_01_00, 16'd0, 1);
        pulse(NS'(1) << 12); expect_slot(12);
        pulse(NS'(1) << 12); expect_slot(12);

        // R10 reserved mode: no strobes, counts down to completion
        setup(20, 32'h44, 32'h88, 6'b01_01_11, 16'd2, 1);
        pulse(NS'(1) << 20); expect_slot(20);
        pulse(NS'(1) << 20); expect_slot(20);

        // R2 R12 enable bit cleared by mode write
        setup(21, 32'h10, 32'h20, 6'b01_01_00, 16'd4, 0);
        pulse(NS'(1) << 21);
        expect_quiet("R2 disabled source ignored", 10);

        // random mix
        for (int it = 0; it < 150; it++) begin
            int idx = $urandom % NS;
            logic [1:0] sz = 2'($urandom % 4);
            logic [5:0] md = {2'($urandom % 4), 2'($urandom % 4), sz};
            logic [1:0] ssz = (sz == 3) ? 2'd0 : sz;
            logic [31:0] amask = ~((32'd1 << ssz) - 1);
            int n = 1 + ($urandom % 3);
            setup(idx, $urandom & amask, $urandom & amask, md, 16'(n), 1);
            for (int k = 0; k < n; k++) begin
                pulse(NS'(1) << idx);
                expect_slot(idx);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule